// File: doc/BRIEF.md
# Indirect Extended Register Access Unit

This block sits behind a management register port that carries a 5-bit register address and 16-bit read and write data. Only two of the directly addressed locations belong to it: a control register and a window register. Together they reach an extended register file that lies above the directly mapped range. The block keeps a 16-bit pointer into that extended space. Each window access goes either to the pointer itself or to the extended register the pointer selects.

The control register holds a 2-bit function field and a 5-bit device address. The function field picks one of four behaviours. Address mode loads the pointer through the window. Data mode with no increment leaves the pointer alone. Data mode with post-increment steps the pointer after every access. Data mode with post-increment on writes only steps the pointer after writes and not after reads. A window transaction has effect only when the device address equals the fixed vendor value. A management agent first programs the control register, then loads the pointer, then streams data through the window.

Each access is a single-cycle strobe. Read data is combinational and valid while the strobe is high. Any pointer change takes effect at the clock edge that ends the strobe.

Top module: `ext_reg_access`

## Requirements
- R1: After reset the control register reads 0x0000, the pointer is 0x0000 and every extended register holds zero.
- R2: The control register sits at direct address 0x0D. Its bits [15:14] are the function field and bits [4:0] are the device address, and both read back as written. Bits [13:5] ignore writes and read as zero.
- R3: With function 00 and a valid device address, a write to the window at direct address 0x0E loads the pointer, and a window read returns the pointer.
- R4: With function 01, a window read or write reaches the extended register the pointer selects, and the pointer does not change.
- R5: With function 10, the pointer increments by one after every window read and after every window write.
- R6: With function 11, the pointer increments by one after a window write, and a window read leaves it unchanged.
- R7: When the device address is not 5'b11111, a window write changes neither the pointer nor any extended register, the pointer does not move, and a window read returns zero.
- R8: The pointer wraps from 0xFFFF to 0x0000 on increment.
- R9: The extended registers occupy pointer values 0x20 to 0x20+EXT_DEPTH-1 (default 0x20 to 0x3F). A data-mode write to a pointer outside that range changes no register, and a read there returns zero. Post-increment still applies.
- R10: A read of any direct address other than 0x0D and 0x0E returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 selects a write, 0 selects a read |
| addr | input | 5 | Direct register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while req is high and we is low |

## Verification
The hardest conditions to reach from the ports are the pointer wrap at 0xFFFF and a pointer that points outside the implemented extended range. The pointer can only be seen through the window while the block is in address mode, so the bench reaches these conditions indirectly. After every data access it switches the function field to 00, reads the pointer back, and restores the previous mode. To reach the wrap, it loads 0xFFFF in address mode and then performs one post-increment access. To reach the out-of-range cases, it loads pointers just below and just above the array.

// File: rtl/ext_reg_access.sv
module ext_reg_access #(
  parameter int DW        = 16,
  parameter int AW        = 5,
  parameter int EXT_DEPTH = 32,
  parameter int EXT_BASE  = 32,
  parameter int CTRL_ADDR = 13,
  parameter int WIN_ADDR  = 14,
  parameter logic [4:0] DEV_ID = 5'h1F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int IW = (EXT_DEPTH > 1) ? $clog2(EXT_DEPTH) : 1;

  logic [1:0]    mode;
  logic [4:0]    devad;
  logic [DW-1:0] ptr;
  logic [DW-1:0] ext_q [EXT_DEPTH];

  wire          hit_ctrl = (addr == AW'(CTRL_ADDR));
  wire          hit_win  = (addr == AW'(WIN_ADDR));
  wire          dev_ok   = (devad == DEV_ID);
  wire          win_go   = req && hit_win && dev_ok;
  wire [DW-1:0] offs     = ptr - DW'(EXT_BASE);
  wire          in_range = (offs < DW'(EXT_DEPTH));
  wire [IW-1:0] idx      = offs[IW-1:0];
  wire          bump     = win_go && ((mode == 2'b10) || (mode == 2'b11 && we));
  wire          ext_wr   = win_go && we && (mode != 2'b00) && in_range;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode  <= 2'b00;
      devad <= 5'd0;
    end else if (req && we && hit_ctrl) begin
      mode  <= wdata[DW-1:DW-2];
      devad <= wdata[4:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           ptr <= '0;
    else if (win_go && we && mode == 2'b00) ptr <= wdata;
    else if (bump)                        ptr <= ptr + DW'(1);

  for (genvar g = 0; g < EXT_DEPTH; g++) begin : g_ext
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           ext_q[g] <= '0;
      else if (ext_wr && idx == IW'(g))     ext_q[g] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (req && !we) begin
      if (hit_ctrl)
        rdata = {mode, {(DW-7){1'b0}}, devad};
      else if (hit_win && dev_ok)
        rdata = (mode == 2'b00) ? ptr : (in_range ? ext_q[idx] : '0);
    end
  end

  // R4
  ptr_hold_m01_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit_win && mode == 2'b01) |=> $stable(ptr));
  // R5
  ptr_step_m10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_go && mode == 2'b10) |=> (ptr == $past(ptr) + DW'(1)));
  // R6
  ptr_hold_rd_m11_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && hit_win && mode == 2'b11) |=> $stable(ptr));
  // R7
  bad_dev_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit_win && !dev_ok) |=> $stable(ptr));
  // R7
  bad_dev_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && hit_win && !dev_ok) |-> (rdata == '0));
  // R2
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && hit_ctrl) |-> (rdata[DW-3:5] == '0));
  // R10
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !hit_ctrl && !hit_win) |-> (rdata == '0));
endmodule

// File: tb/tb_ext_reg_access.sv
module tb_ext_reg_access;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int BASE  = 32;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [4:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_ptr;
  logic [15:0] m_mem [DEPTH];
  logic [1:0]  m_mode;
  logic [4:0]  m_dev;

  ext_reg_access dut (.clk(clk), .rst_n(rst_n), .req(req), .we(we),
                      .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(bit w, logic [4:0] a, logic [15:0] d, output logic [15:0] rd);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #(CLK_P/4) rd = rdata;
    @(posedge clk);
    #1 req = 0; we = 0;
  endtask

  task automatic set_ctl(logic [1:0] md, logic [4:0] dv);
    logic [15:0] r;
    acc(1, 5'h0D, {md, 9'h1FF, dv}, r);
    m_mode = md; m_dev = dv;
  endtask

  function automatic logic [15:0] mem_rd(logic [15:0] p);
    logic [15:0] o = p - 16'(BASE);
    return (o < 16'(DEPTH)) ? m_mem[o[4:0]] : 16'h0;
  endfunction

  task automatic peek_ptr(string tag);
    logic [1:0] sm = m_mode; logic [4:0] sd = m_dev; logic [15:0] r;
    set_ctl(2'b00, 5'h1F);
    acc(0, 5'h0E, 0, r);
    check(tag, r, m_ptr);
    set_ctl(sm, sd);
  endtask

  task automatic load_ptr(logic [15:0] p);
    logic [1:0] sm = m_mode; logic [4:0] sd = m_dev; logic [15:0] r;
    set_ctl(2'b00, 5'h1F);
    acc(1, 5'h0E, p, r);
    m_ptr = p;
    set_ctl(sm, sd);
  endtask

  task automatic win_wr(logic [15:0] d, string tag);
    logic [15:0] r; logic [15:0] o;
    acc(1, 5'h0E, d, r);
    if (m_dev == 5'h1F) begin
      o = m_ptr - 16'(BASE);
      if (o < 16'(DEPTH)) m_mem[o[4:0]] = d;
      if (m_mode[1]) m_ptr = m_ptr + 1;
    end
    peek_ptr(tag);
  endtask

  task automatic win_rd(string tag);
    logic [15:0] r;
    acc(0, 5'h0E, 0, r);
    check(tag, r, (m_dev == 5'h1F) ? mem_rd(m_ptr) : 16'h0);
    if (m_dev == 5'h1F && m_mode == 2'b10) m_ptr = m_ptr + 1;
    peek_ptr(tag);
  endtask

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    m_ptr = 0; m_mode = 0; m_dev = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    #(CLK_P*3) rst_n = 1;

    // R1 reset state
    acc(0, 5'h0D, 0, r); check("R1 ctrl", r, 16'h0000);
    set_ctl(2'b00, 5'h1F);
    acc(0, 5'h0E, 0, r); check("R1 ptr", r, 16'h0000);
    // R2 readback and reserved bits
    set_ctl(2'b10, 5'h15);
    acc(0, 5'h0D, 0, r); check("R2 ctrl", r, 16'h8015);
    set_ctl(2'b11, 5'h1F);
    acc(0, 5'h0D, 0, r); check("R2 ctrl", r, 16'hC01F);
    // R10 other addresses
    for (int a = 0; a < 32; a++)
      if (a != 13 && a != 14) begin
        acc(0, 5'(a), 0, r); check("R10 other", r, 16'h0);
      end
    // R3 pointer load and readback
    load_ptr(16'h1234); peek_ptr("R3 load");
    load_ptr(16'(BASE)); peek_ptr("R3 load");
    // R1 extended registers cleared, R4 reads in mode 01
    set_ctl(2'b01, 5'h1F);
    for (int i = 0; i < DEPTH; i++) begin
      load_ptr(16'(BASE + i)); win_rd("R1 R4 zero");
    end
    // R6 write burst in mode 11
    load_ptr(16'(BASE));
    set_ctl(2'b11, 5'h1F);
    for (int i = 0; i < DEPTH; i++) win_wr(16'(i * 16'h1357) ^ 16'hA5A5, "R6 wr");
    // R6 reads do not move
    load_ptr(16'(BASE + 5));
    win_rd("R6 rd"); win_rd("R6 rd");
    // R5 read burst in mode 10
    load_ptr(16'(BASE));
    set_ctl(2'b10, 5'h1F);
    for (int i = 0; i < DEPTH; i++) win_rd("R5 rd");
    // R5 write then read in mode 10
    load_ptr(16'(BASE + 3)); win_wr(16'hBEEF, "R5 wr");
    load_ptr(16'(BASE + 3)); win_rd("R5 rd");
    // R4 write in mode 01
    set_ctl(2'b01, 5'h1F);
    load_ptr(16'(BASE + 7)); win_wr(16'h0F0F, "R4 wr"); win_rd("R4 rd");
    // R7 wrong device address
    for (int m = 0; m < 4; m++) begin
      set_ctl(2'(m), 5'h1E);
      win_wr(16'hDEAD, "R7 wr"); win_rd("R7 rd");
    end
    set_ctl(2'b01, 5'h1F); win_rd("R7 data kept");
    // R8 wrap
    set_ctl(2'b10, 5'h1F);
    load_ptr(16'hFFFF); win_rd("R8 wrap rd");
    set_ctl(2'b11, 5'h1F);
    load_ptr(16'hFFFF); win_wr(16'h7777, "R8 wrap wr");
    // R9 outside the array
    set_ctl(2'b10, 5'h1F);
    load_ptr(16'(BASE - 1)); win_wr(16'h5555, "R9 below"); win_rd("R9 first");
    load_ptr(16'(BASE - 1)); win_rd("R9 below rd");
    load_ptr(16'(BASE + DEPTH)); win_wr(16'h6666, "R9 above");
    load_ptr(16'(BASE + DEPTH)); win_rd("R9 above rd");
    set_ctl(2'b01, 5'h1F);
    for (int i = 0; i < DEPTH; i++) begin
      load_ptr(16'(BASE + i)); win_rd("R9 array intact");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule